// File: doc/BRIEF.md
# Bank Select XOR Interleave Mapper

This block turns a linear request address into DRAM coordinates: a module-bank select, two component-bank bits, a row field and a column field. Two interleave modes are available. In high-order mode, fixed upper address bits pick the bank, so each bank owns one large contiguous region. In low-order mode, the bits just above the column field pick the bank, so neighbouring pages fall in different banks. In low-order mode, each of the three select bits can also be XORed with one upper address bit chosen by a 2-bit selector. Large aligned regions then start on different banks instead of all beginning on bank zero.

The mapping is combinational. Its result is captured in one output register together with a valid flag, so the outputs appear one clock after the input is presented. While the input valid is low the register holds its last contents. Configuration arrives as plain input levels, and the mode input drives a two-entry enumerated selector (low-order, high-order) that picks which map feeds the register.

Top module: `bxm_mapper`

## Requirements
- R1: While reset (rst_n low) is asserted, and on the first cycle after it, out_valid is 0 and out_mb, out_ba, out_row and out_col are all 0.
- R2: When in_valid is 1 at a rising clock edge, out_valid is 1 after that edge and the mapped fields of the address sampled at that edge appear on the outputs. When in_valid is 0 at the edge, out_valid is 0 after it.
- R3: When in_valid is 0 at a rising edge, out_mb, out_ba, out_row and out_col keep their previous values whatever the address and configuration inputs carry.
- R4: out_col equals address bits 9..0 in both modes.
- R5: With cfg_hi_mode = 0 (low-order) and all XOR enables 0: out_ba[0] = address bit 10, out_ba[1] = bit 11, out_mb = bit 12, and out_row = address bits 31..13.
- R6: With cfg_hi_mode = 1 (high-order): out_ba[0] = address bit 26, out_ba[1] = bit 27, out_mb = bit 28, and out_row = {address bits 31..29, address bits 25..10}, the upper three bits in the most significant positions.
- R7: cfg_xor_sel picks the XOR source bit: 2'b00 picks address bit 18, 2'b01 bit 19, 2'b10 bit 20 and 2'b11 bit 21.
- R8: In low-order mode, cfg_xor_ba0, cfg_xor_ba1 and cfg_xor_mb each independently invert out_ba[0], out_ba[1] and out_mb respectively when the selected source bit is 1. A select bit whose enable is 0 keeps its plain low-order value.
- R9: In high-order mode, cfg_xor_sel and the three XOR enables have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The address on in_addr is to be mapped |
| in_addr | input | 32 | Linear request address |
| cfg_hi_mode | input | 1 | Interleave mode: 1 high-order, 0 low-order |
| cfg_xor_sel | input | 2 | XOR source select: address bit 18 + value |
| cfg_xor_mb | input | 1 | Enable XOR on the module-bank select |
| cfg_xor_ba1 | input | 1 | Enable XOR on bank bit 1 |
| cfg_xor_ba0 | input | 1 | Enable XOR on bank bit 0 |
| out_valid | output | 1 | Registered fields below are fresh |
| out_mb | output | 1 | Module-bank select |
| out_ba | output | 2 | Component-bank bits |
| out_row | output | 19 | Row field |
| out_col | output | 10 | Column field |

## Verification
Two functions can act in the same cycle: XOR scrambling and the mode selection that must override it. Random stimulus sets XOR enables and selector values together with both mode levels, and several directed cases raise every enable with each source bit set while high-order mode is chosen. In those cycles the bank bits must equal the raw upper address bits exactly. A second overlap is a held register (in_valid low) while configuration and address keep changing. The bench judges that cycle by comparing against the previous expected result, not the current inputs.

// File: rtl/bxm_pkg.sv
package bxm_pkg;

    // Interleave mode, encoded to match the mode input level.
    typedef enum logic {
        IL_LOW  = 1'b0,
        IL_HIGH = 1'b1
    } il_mode_e;

    // Bank selection bundle produced by either map.
    typedef struct packed {
        logic       mb;
        logic [1:0] ba;
    } bank_sel_t;

endpackage

// File: rtl/bxm_xor_src.sv
// Picks the upper address bit used to scramble bank selects.
module bxm_xor_src #(
    parameter int SEL_W = 2,
    localparam int WIN_W = 1 << SEL_W
) (
    input  logic [WIN_W-1:0] win,
    input  logic [SEL_W-1:0] sel,
    output logic             src_bit
);

    always_comb begin
        src_bit = win[sel];
    end

endmodule

// File: rtl/bxm_lo_map.sv
// Low-order map: bank bits sit just above the column field, optional XOR.
module bxm_lo_map
    import bxm_pkg::*;
#(
    parameter int UP_W  = 22,
    parameter int ROW_W = 19
) (
    input  logic [UP_W-1:0] up_addr,  // address with the column bits removed
    input  logic [2:0]      xor_en,   // {mb, ba1, ba0}
    input  logic            src_bit,
    output bank_sel_t       bank,
    output logic [ROW_W-1:0] row
);

    logic [2:0] sel_bits;

    // One scrambler slice per select bit: 0 -> ba0, 1 -> ba1, 2 -> mb.
    for (genvar i = 0; i < 3; i++) begin : g_slice
        assign sel_bits[i] = up_addr[i] ^ (xor_en[i] & src_bit);
    end

    always_comb begin
        bank.ba = sel_bits[1:0];
        bank.mb = sel_bits[2];
        row     = up_addr[UP_W-1:3];
    end

endmodule

// File: rtl/bxm_hi_map.sv
// High-order map: bank bits come from fixed upper address bits.
module bxm_hi_map
    import bxm_pkg::*;
#(
    parameter int UP_W   = 22,
    parameter int ROW_W  = 19,
    parameter int HI_OFS = 16   // bank LSB position inside up_addr
) (
    input  logic [UP_W-1:0]  up_addr,
    output bank_sel_t        bank,
    output logic [ROW_W-1:0] row
);

    always_comb begin
        bank.ba = up_addr[HI_OFS+1:HI_OFS];
        bank.mb = up_addr[HI_OFS+2];
        row     = {up_addr[UP_W-1:HI_OFS+3], up_addr[HI_OFS-1:0]};
    end

endmodule

// File: rtl/bxm_mapper.sv
module bxm_mapper
    import bxm_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int COL_W    = 10,
    parameter int HI_LSB   = 26,
    parameter int XOR_BASE = 18,
    parameter int SEL_W    = 2,
    localparam int UP_W    = ADDR_W - COL_W,
    localparam int ROW_W   = ADDR_W - COL_W - 3,
    localparam int WIN_W   = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              cfg_hi_mode,
    input  logic [SEL_W-1:0]  cfg_xor_sel,
    input  logic              cfg_xor_mb,
    input  logic              cfg_xor_ba1,
    input  logic              cfg_xor_ba0,
    output logic              out_valid,
    output logic              out_mb,
    output logic [1:0]        out_ba,
    output logic [ROW_W-1:0]  out_row,
    output logic [COL_W-1:0]  out_col
);

    logic [UP_W-1:0]  up_addr;
    logic             src_bit;
    bank_sel_t        lo_bank, hi_bank, nxt_bank;
    logic [ROW_W-1:0] lo_row, hi_row, nxt_row;
    il_mode_e         mode;

    assign up_addr = in_addr[ADDR_W-1:COL_W];
    assign mode    = il_mode_e'(cfg_hi_mode);

    bxm_xor_src #(.SEL_W(SEL_W)) i_src (
        .win     (in_addr[XOR_BASE+WIN_W-1:XOR_BASE]),
        .sel     (cfg_xor_sel),
        .src_bit (src_bit)
    );

    bxm_lo_map #(.UP_W(UP_W), .ROW_W(ROW_W)) i_lo (
        .up_addr (up_addr),
        .xor_en  ({cfg_xor_mb, cfg_xor_ba1, cfg_xor_ba0}),
        .src_bit (src_bit),
        .bank    (lo_bank),
        .row     (lo_row)
    );

    bxm_hi_map #(.UP_W(UP_W), .ROW_W(ROW_W), .HI_OFS(HI_LSB - COL_W)) i_hi (
        .up_addr (up_addr),
        .bank    (hi_bank),
        .row     (hi_row)
    );

    // Mode selection between the two maps.
    always_comb begin
        unique case (mode)
            IL_LOW: begin
                nxt_bank = lo_bank;
                nxt_row  = lo_row;
            end
            IL_HIGH: begin
                nxt_bank = hi_bank;
                nxt_row  = hi_row;
            end
            default: begin
                nxt_bank = lo_bank;
                nxt_row  = lo_row;
            end
        endcase
    end

    // Output register: loads on valid, holds otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mb    <= 1'b0;
            out_ba    <= '0;
            out_row   <= '0;
            out_col   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_mb  <= nxt_bank.mb;
                out_ba  <= nxt_bank.ba;
                out_row <= nxt_row;
                out_col <= in_addr[COL_W-1:0];
            end
        end
    end

    // ---------------- assertions ----------------
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    p_valid_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_row) && $stable(out_col)
                       && $stable(out_ba) && $stable(out_mb)));

    p_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_col == $past(in_addr[COL_W-1:0]));

    p_lo_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_hi_mode && !cfg_xor_ba0 && !cfg_xor_ba1 && !cfg_xor_mb)
        |=> (out_ba == $past(in_addr[COL_W+1:COL_W]))
            && (out_mb == $past(in_addr[COL_W+2])));

    p_hi_bank_r6_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_hi_mode)
        |=> (out_ba == $past(in_addr[HI_LSB+1:HI_LSB]))
            && (out_mb == $past(in_addr[HI_LSB+2])));

    p_lo_xor_mb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_hi_mode && cfg_xor_mb)
        |=> out_mb == ($past(in_addr[COL_W+2])
                       ^ $past(in_addr[XOR_BASE + int'(cfg_xor_sel)])));

endmodule

// File: tb/test_bxm_mapper.sv
module test_bxm_mapper;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        cfg_hi_mode = 1'b0;
    logic [1:0]  cfg_xor_sel = '0;
    logic        cfg_xor_mb = 1'b0;
    logic        cfg_xor_ba1 = 1'b0;
    logic        cfg_xor_ba0 = 1'b0;
    logic        out_valid;
    logic        out_mb;
    logic [1:0]  out_ba;
    logic [18:0] out_row;
    logic [9:0]  out_col;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] prev_exp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bxm_mapper i_bxm_mapper (
        .clk, .rst_n, .in_valid, .in_addr, .cfg_hi_mode, .cfg_xor_sel,
        .cfg_xor_mb, .cfg_xor_ba1, .cfg_xor_ba0,
        .out_valid, .out_mb, .out_ba, .out_row, .out_col
    );

    // Expected bundle {mb, ba1, ba0, row[18:0], col[9:0]} from the requirements.
    function automatic logic [31:0] expect_map(input logic [31:0] a, input logic hi,
                                               input logic [1:0] sel, input logic [2:0] en);
        logic s, mb, b1, b0;
        logic [18:0] row;
        s = a[18 + int'(sel)];               // R7
        if (hi) begin                        // R6, R9
            b0 = a[26]; b1 = a[27]; mb = a[28];
            row = {a[31:29], a[25:10]};
        end else begin                       // R5, R8
            b0 = a[10] ^ (en[0] & s);
            b1 = a[11] ^ (en[1] & s);
            mb = a[12] ^ (en[2] & s);
            row = a[31:13];
        end
        return {mb, b1, b0, row, a[9:0]};    // R4 column
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at negedge, check at the following negedge (one register of latency).
    task automatic apply(input string tag, input logic v, input logic [31:0] a,
                         input logic hi, input logic [1:0] sel, input logic [2:0] en);
        logic [31:0] e;
        in_valid = v; in_addr = a; cfg_hi_mode = hi; cfg_xor_sel = sel;
        {cfg_xor_mb, cfg_xor_ba1, cfg_xor_ba0} = en;
        e = v ? expect_map(a, hi, sel, en) : prev_exp;
        @(negedge clk);
        check({tag, " R2 valid"}, {31'd0, out_valid}, {31'd0, v});
        check(v ? tag : {tag, " R3 hold"}, {out_mb, out_ba, out_row, out_col}, e);
        prev_exp = e;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset fields", {out_mb, out_ba, out_row, out_col}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {out_valid, out_mb, out_ba, out_row, out_col}, 33'd0);

        // R5: plain low-order, bank bits walk
        apply("R5 lo ba0", 1, 32'h0000_0400, 0, 2'b00, 3'b000);
        apply("R5 lo ba1", 1, 32'h0000_0800, 0, 2'b00, 3'b000);
        apply("R5 lo mb",  1, 32'h0000_1000, 0, 2'b00, 3'b000);
        apply("R4 R5 lo mixed", 1, 32'hDEAD_BEEF, 0, 2'b00, 3'b000);
        // R6: high-order
        apply("R6 hi ba0", 1, 32'h0400_0000, 1, 2'b00, 3'b000);
        apply("R6 hi mb",  1, 32'h1000_0000, 1, 2'b00, 3'b000);
        apply("R6 hi mixed", 1, 32'hCAFE_F00D, 1, 2'b00, 3'b000);
        // R7 and R8: each selector value, each enable alone
        for (int s = 0; s < 4; s++) begin
            apply("R7 sel all en", 1, 32'h1 << (18 + s), 0, 2'(s), 3'b111);
            apply("R7 sel wrong bit", 1, 32'h1 << (18 + ((s + 1) % 4)), 0, 2'(s), 3'b111);
        end
        for (int k = 0; k < 3; k++)
            apply("R8 single enable", 1, 32'h003C_1C00, 0, 2'b01, 3'(1 << k));
        // R9: enables and source bits on in high-order mode
        apply("R9 hi xor ignored", 1, 32'h003C_0000, 1, 2'b10, 3'b111);
        apply("R9 hi xor ignored 2", 1, 32'h1C3C_0000, 1, 2'b11, 3'b111);
        // R3: hold while inputs change
        apply("R3 idle", 0, 32'hFFFF_FFFF, 1, 2'b11, 3'b111);
        apply("R3 idle 2", 0, 32'h1234_5678, 0, 2'b01, 3'b101);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic v;
            v = ($urandom % 4) != 0;
            apply("R2 random", v, $urandom, 1'($urandom), 2'($urandom), 3'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule